// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This block is the request-tracking and arbitration core of a per-processor interrupt controller. It takes one interrupt message per cycle, each carrying an 8-bit vector, a 3-bit delivery mode and a level/edge flag. Ordinary deliveries (fixed and lowest priority) are recorded in a 256-entry request array, with a matching trigger-mode array. Special deliveries (system management, non-maskable, init and external) skip the arrays. Each of them goes into a single pending slot that also holds its vector.

Every cycle the unit offers the core at most one interrupt: the most urgent one that may be delivered, given the core's interrupt-enable input and a 4-bit priority threshold. The core takes the offered interrupt with a one-cycle acknowledge pulse. Taking an ordinary vector moves it from the request array into the in-service array. A separate end-of-interrupt pulse removes the highest in-service vector, which can let a lower request through. Message routing and destination matching happen before this block.

Top module: `intacc_core`

## Requirements
- R1: After synchronous reset, all arrays and special slots are empty and `pres_valid` is 0.
- R2: A message with mode 000 (fixed) or 001 (lowest priority) sets the request bit of its vector. The trigger bit for that vector is set when `msg_level` is 1 and cleared when it is 0. When that vector is offered as an ordinary interrupt, `pres_level` carries its trigger bit.
- R3: An ordinary message whose vector already has its request bit set changes nothing, including that vector's trigger bit.
- R4: Modes 010 (system management), 100 (non-maskable), 101 (init) and 111 (external) each arm their own slot and store the message vector. A message for a slot that is already armed is ignored, and the stored vector is kept.
- R5: Messages with the reserved modes 011 and 110 have no effect.
- R6: The system management, non-maskable and init slots are offered whatever the value of `core_ie`. External and ordinary interrupts are offered only while `core_ie` is 1.
- R7: An ordinary interrupt is offered only when both of these hold: the highest requested vector is above the highest in-service vector (an empty in-service array counts as below every vector), and bits 7:4 of that vector are greater than `tpr_class`.
- R8: When several interrupts are pending, the one offered is chosen in this order: system management, non-maskable, init, external, then the highest ordinary vector.
- R9: Acknowledging an ordinary interrupt sets its in-service bit and clears its request bit. The next cycle offers the next eligible request.
- R10: Acknowledging a special interrupt disarms its slot.
- R11: An end-of-interrupt pulse clears the highest set in-service bit. With the in-service array empty it does nothing.
- R12: `ack` while `pres_valid` is 0 has no effect.
- R13: `pres_kind` is coded as 0 none, 1 system management, 2 non-maskable, 3 init, 4 external, 5 ordinary. `pres_vector` carries the offered vector, and `pres_level` is 0 for every kind except ordinary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_valid | input | 1 | Message strobe |
| msg_vector | input | 8 | Message vector |
| msg_mode | input | 3 | Delivery mode code |
| msg_level | input | 1 | 1 = level triggered, 0 = edge |
| core_ie | input | 1 | Core interrupt-enable flag |
| tpr_class | input | 4 | Priority-class threshold |
| ack | input | 1 | Core takes the offered interrupt |
| eoi | input | 1 | End of the highest in-service interrupt |
| pres_valid | output | 1 | An interrupt is offered |
| pres_kind | output | 3 | Kind of the offered interrupt |
| pres_vector | output | 8 | Vector of the offered interrupt |
| pres_level | output | 1 | Trigger bit of an offered ordinary vector |

## Verification
Ordinary vectors are sent both above and below the in-service vector. This tells the in-service comparison apart from the threshold comparison, and a class that equals `tpr_class` probes the strict inequality. Duplicate messages with the opposite trigger flag expose any accidental rewrite of the trigger bits. Duplicate special messages with a fresh vector expose any overwrite of a stored vector. Stacking all four special kinds and an ordinary request with `core_ie` low, then acknowledging them one at a time and raising the enable partway, checks the fixed order and the enable gating. Stray acknowledges, end-of-interrupt pulses with nothing in service, and reserved mode codes check that these inputs leave the state alone.

// File: rtl/intacc_pkg.sv
package intacc_pkg;

    localparam int VW       = 8;
    localparam int CLS_W    = 4;
    localparam int NUM_SPEC = 4;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'b000,
        DM_LOWEST = 3'b001,
        DM_SMI    = 3'b010,
        DM_RSV_A  = 3'b011,
        DM_NMI    = 3'b100,
        DM_INIT   = 3'b101,
        DM_RSV_B  = 3'b110,
        DM_EXT    = 3'b111
    } dmode_e;

    typedef enum logic [2:0] {
        PK_NONE = 3'd0,
        PK_SMI  = 3'd1,
        PK_NMI  = 3'd2,
        PK_INIT = 3'd3,
        PK_EXT  = 3'd4,
        PK_REG  = 3'd5
    } pkind_e;

    typedef struct packed {
        logic          valid;
        pkind_e        kind;
        logic [VW-1:0] vec;
        logic          level;
    } offer_t;

    // Slot index order equals precedence order.
    function automatic dmode_e slot_mode(input int k);
        case (k)
            0:       return DM_SMI;
            1:       return DM_NMI;
            2:       return DM_INIT;
            default: return DM_EXT;
        endcase
    endfunction

    function automatic pkind_e slot_kind(input int k);
        case (k)
            0:       return PK_SMI;
            1:       return PK_NMI;
            2:       return PK_INIT;
            default: return PK_EXT;
        endcase
    endfunction

    function automatic logic is_ordinary(input dmode_e m);
        return (m == DM_FIXED) || (m == DM_LOWEST);
    endfunction

endpackage

// File: rtl/intacc_prio_enc.sv
module intacc_prio_enc #(
    parameter int N = 256,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] bits,
    output logic         found,
    output logic [W-1:0] top
);
    always_comb begin
        found = 1'b0;
        top   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                top   = W'(i);
            end
        end
    end
endmodule

// File: rtl/intacc_bitvec.sv
module intacc_bitvec #(
    parameter int N = 256,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_en,
    input  logic [W-1:0] set_idx,
    input  logic         clr_en,
    input  logic [W-1:0] clr_idx,
    output logic [N-1:0] bits
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[g] <= 1'b0;
            else if (set_en && set_idx == W'(g))
                bits[g] <= 1'b1;
            else if (clr_en && clr_idx == W'(g))
                bits[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/intacc_spec_slot.sv
module intacc_spec_slot #(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic [VEC_W-1:0] arm_vec,
    input  logic             retire,
    output logic             pending,
    output logic [VEC_W-1:0] vec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            vec     <= '0;
        end else if (retire) begin
            pending <= 1'b0;
        end else if (arm && !pending) begin
            pending <= 1'b1;
            vec     <= arm_vec;
        end
    end
endmodule

// File: rtl/intacc_core.sv
module intacc_core
    import intacc_pkg::*;
#(
    parameter int VEC_W   = intacc_pkg::VW,
    parameter int CLASS_W = intacc_pkg::CLS_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               msg_valid,
    input  logic [VEC_W-1:0]   msg_vector,
    input  logic [2:0]         msg_mode,
    input  logic               msg_level,
    input  logic               core_ie,
    input  logic [CLASS_W-1:0] tpr_class,
    input  logic               ack,
    input  logic               eoi,
    output logic               pres_valid,
    output logic [2:0]         pres_kind,
    output logic [VEC_W-1:0]   pres_vector,
    output logic               pres_level
);
    localparam int NUM_VEC = 1 << VEC_W;

    dmode_e             mode;
    logic               accept_reg;
    logic [NUM_VEC-1:0] req_bits, isr_bits, tmr_bits;
    logic               req_found, isr_found;
    logic [VEC_W-1:0]   req_top, isr_top;
    logic               reg_ok;
    logic [NUM_SPEC-1:0]  spec_pend, spec_arm, spec_retire;
    logic [VEC_W-1:0]     spec_vec [NUM_SPEC];
    offer_t             offer;
    logic               take, take_reg;

    assign mode       = dmode_e'(msg_mode);
    assign accept_reg = msg_valid && is_ordinary(mode) && !req_bits[msg_vector];

    // Highest-bit search over request and in-service arrays
    intacc_prio_enc #(.N(NUM_VEC)) u_req_enc (
        .bits(req_bits), .found(req_found), .top(req_top));
    intacc_prio_enc #(.N(NUM_VEC)) u_isr_enc (
        .bits(isr_bits), .found(isr_found), .top(isr_top));

    assign reg_ok = core_ie && req_found
                 && (!isr_found || req_top > isr_top)
                 && (req_top[VEC_W-1 -: CLASS_W] > tpr_class);

    // Special delivery slots
    for (genvar k = 0; k < NUM_SPEC; k++) begin : g_slot
        assign spec_arm[k]    = msg_valid && (mode == slot_mode(k));
        assign spec_retire[k] = take && (offer.kind == slot_kind(k));
        intacc_spec_slot #(.VEC_W(VEC_W)) u_slot (
            .clk(clk), .rst(rst),
            .arm(spec_arm[k]), .arm_vec(msg_vector),
            .retire(spec_retire[k]),
            .pending(spec_pend[k]), .vec(spec_vec[k]));
    end

    // Fixed precedence selection
    always_comb begin
        offer = '{valid: 1'b0, kind: PK_NONE, vec: '0, level: 1'b0};
        if (spec_pend[0]) begin
            offer = '{valid: 1'b1, kind: PK_SMI, vec: spec_vec[0], level: 1'b0};
        end else if (spec_pend[1]) begin
            offer = '{valid: 1'b1, kind: PK_NMI, vec: spec_vec[1], level: 1'b0};
        end else if (spec_pend[2]) begin
            offer = '{valid: 1'b1, kind: PK_INIT, vec: spec_vec[2], level: 1'b0};
        end else if (spec_pend[3] && core_ie) begin
            offer = '{valid: 1'b1, kind: PK_EXT, vec: spec_vec[3], level: 1'b0};
        end else if (reg_ok) begin
            offer = '{valid: 1'b1, kind: PK_REG, vec: req_top, level: tmr_bits[req_top]};
        end
    end

    assign take     = ack && offer.valid;
    assign take_reg = take && (offer.kind == PK_REG);

    intacc_bitvec #(.N(NUM_VEC)) u_req (
        .clk(clk), .rst(rst),
        .set_en(accept_reg), .set_idx(msg_vector),
        .clr_en(take_reg),   .clr_idx(req_top),
        .bits(req_bits));

    intacc_bitvec #(.N(NUM_VEC)) u_isr (
        .clk(clk), .rst(rst),
        .set_en(take_reg),         .set_idx(req_top),
        .clr_en(eoi && isr_found), .clr_idx(isr_top),
        .bits(isr_bits));

    intacc_bitvec #(.N(NUM_VEC)) u_tmr (
        .clk(clk), .rst(rst),
        .set_en(accept_reg && msg_level),  .set_idx(msg_vector),
        .clr_en(accept_reg && !msg_level), .clr_idx(msg_vector),
        .bits(tmr_bits));

    assign pres_valid  = offer.valid;
    assign pres_kind   = offer.kind;
    assign pres_vector = offer.vec;
    assign pres_level  = offer.level;

endmodule

// File: rtl/intacc_checker.sv
module intacc_checker #(
    parameter int VEC_W   = 8,
    parameter int CLASS_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic [2:0]         msg_mode,
    input logic               core_ie,
    input logic [CLASS_W-1:0] tpr_class,
    input logic               ack,
    input logic               pres_valid,
    input logic [2:0]         pres_kind,
    input logic [VEC_W-1:0]   pres_vector
);
    AST_MASKABLE_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        pres_valid && (pres_kind == 3'd4 || pres_kind == 3'd5) |-> core_ie); // R6

    AST_REG_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
        pres_valid && pres_kind == 3'd5 |-> pres_vector[VEC_W-1 -: CLASS_W] > tpr_class); // R7

    AST_SMI_TAKES_LEAD: assert property (@(posedge clk) disable iff (rst)
        msg_valid && msg_mode == 3'b010 && !ack |=> pres_valid && pres_kind == 3'd1); // R8

    AST_SPECIAL_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
        ack && pres_valid && pres_kind == 3'd1 |=> pres_kind != 3'd1); // R10

    AST_IDLE_IS_NONE: assert property (@(posedge clk) disable iff (rst)
        !pres_valid |-> pres_kind == 3'd0); // R13
endmodule

bind intacc_core intacc_checker #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_chk (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_mode(msg_mode),
    .core_ie(core_ie), .tpr_class(tpr_class), .ack(ack),
    .pres_valid(pres_valid), .pres_kind(pres_kind), .pres_vector(pres_vector));

// File: tb/intacc_core_test.sv
`timescale 1ns/1ps
module intacc_core_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_valid = 1'b0;
    logic [7:0] msg_vector = '0;
    logic [2:0] msg_mode = '0;
    logic       msg_level = 1'b0;
    logic       core_ie = 1'b1;
    logic [3:0] tpr_class = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       pres_valid;
    logic [2:0] pres_kind;
    logic [7:0] pres_vector;
    logic       pres_level;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    bit [255:0] m_req, m_isr, m_tmr;
    bit         m_pend [4];
    bit [7:0]   m_vec  [4];

    always #4 clk = ~clk;

    intacc_core uut (
        .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_mode(msg_mode), .msg_level(msg_level), .core_ie(core_ie),
        .tpr_class(tpr_class), .ack(ack), .eoi(eoi),
        .pres_valid(pres_valid), .pres_kind(pres_kind),
        .pres_vector(pres_vector), .pres_level(pres_level));

    function automatic int top_of(input bit [255:0] b);
        for (int i = 255; i >= 0; i--) if (b[i]) return i;
        return -1;
    endfunction

    task automatic expect_offer(output bit v, output int kind, output int vec, output bit lvl);
        int rt, it;
        v = 0; kind = 0; vec = 0; lvl = 0;
        rt = top_of(m_req);
        it = top_of(m_isr);
        if (m_pend[0])      begin v = 1; kind = 1; vec = m_vec[0]; end
        else if (m_pend[1]) begin v = 1; kind = 2; vec = m_vec[1]; end
        else if (m_pend[2]) begin v = 1; kind = 3; vec = m_vec[2]; end
        else if (m_pend[3] && core_ie) begin v = 1; kind = 4; vec = m_vec[3]; end
        else if (core_ie && rt >= 0 && rt > it && (rt / 16) > int'(tpr_class)) begin
            v = 1; kind = 5; vec = rt; lvl = m_tmr[rt];
        end
    endtask

    task automatic compare();
        bit v, lvl; int kind, vec;
        expect_offer(v, kind, vec, lvl);
        checks++;
        if (pres_valid !== v || (v && (int'(pres_kind) != kind || int'(pres_vector) != vec
                                       || pres_level !== lvl)) || (!v && pres_kind !== 3'd0)) begin
            errors++;
            $display("FAIL %s: got valid=%0b kind=%0d vec=%02h lvl=%0b, expected valid=%0b kind=%0d vec=%02h lvl=%0b",
                     cur_req, pres_valid, pres_kind, pres_vector, pres_level, v, kind, vec, lvl);
        end
    endtask

    task automatic model_update();
        bit v, lvl; int kind, vec, it, k;
        bit [255:0] old_req, old_isr;
        bit old_pend [4];
        expect_offer(v, kind, vec, lvl);
        old_req = m_req; old_isr = m_isr; old_pend = m_pend;
        if (ack && v) begin
            if (kind == 5) begin m_isr[vec] = 1; m_req[vec] = 0; end
            else m_pend[kind-1] = 0;
        end
        if (eoi) begin
            it = top_of(old_isr);
            if (it >= 0) m_isr[it] = 0;
        end
        if (msg_valid) begin
            k = -1;
            case (msg_mode)
                3'b000, 3'b001: if (!old_req[msg_vector]) begin
                    m_req[msg_vector] = 1; m_tmr[msg_vector] = msg_level;
                end
                3'b010: k = 0;
                3'b100: k = 1;
                3'b101: k = 2;
                3'b111: k = 3;
                default: ;
            endcase
            if (k >= 0 && !old_pend[k]) begin m_pend[k] = 1; m_vec[k] = msg_vector; end
        end
    endtask

    // one cycle: compare at mid-low phase, update model at edge, drop pulses
    task automatic step();
        #1 compare();
        @(posedge clk);
        if (!rst) model_update();
        @(negedge clk);
        msg_valid = 0; ack = 0; eoi = 0;
    endtask

    task automatic send(input logic [2:0] md, input logic [7:0] v, input logic lv);
        msg_valid = 1; msg_mode = md; msg_vector = v; msg_level = lv;
        step();
    endtask
    task automatic do_ack(); ack = 1; step(); endtask
    task automatic do_eoi(); eoi = 1; step(); endtask
    task automatic idle(input int n); for (int i = 0; i < n; i++) step(); endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin m_pend[k] = 0; m_vec[k] = 0; end
        m_req = '0; m_isr = '0; m_tmr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        cur_req = "R1"; idle(2);

        cur_req = "R2"; send(3'b000, 8'h45, 0); idle(1);
        send(3'b001, 8'h30, 1); idle(1);
        cur_req = "R3"; send(3'b000, 8'h45, 1); idle(2);
        cur_req = "R9"; do_ack(); idle(1);
        cur_req = "R11"; do_eoi(); idle(1);
        cur_req = "R9"; do_ack(); idle(1);
        cur_req = "R11"; do_eoi(); idle(1);
        do_eoi(); idle(1);                      // empty in-service array

        cur_req = "R7"; tpr_class = 4'd5;
        send(3'b000, 8'h50, 0); idle(1);        // class equals threshold
        send(3'b000, 8'h60, 1); idle(1);
        do_ack(); idle(1);
        do_eoi(); idle(1);
        tpr_class = 4'd0; idle(1);
        do_ack(); do_eoi(); idle(1);

        cur_req = "R6"; core_ie = 0;
        send(3'b000, 8'h70, 0); idle(1);
        send(3'b111, 8'h21, 0); idle(1);
        cur_req = "R12"; do_ack(); idle(1);
        cur_req = "R6"; core_ie = 1; idle(1);
        core_ie = 0; idle(1);

        cur_req = "R8";
        send(3'b100, 8'h02, 0); idle(1);
        send(3'b010, 8'h03, 0);
        send(3'b101, 8'h04, 0); idle(1);
        cur_req = "R10"; do_ack(); idle(1);
        do_ack(); idle(1);
        cur_req = "R13"; do_ack(); idle(1);
        core_ie = 1; idle(1);
        do_ack(); idle(1);
        cur_req = "R9"; do_ack(); idle(1);
        do_eoi(); idle(1);

        cur_req = "R4";
        send(3'b100, 8'h11, 0);
        send(3'b100, 8'h22, 0); idle(1);
        do_ack(); idle(1);
        send(3'b111, 8'h33, 0);
        send(3'b111, 8'h44, 0); idle(1);
        do_ack(); idle(1);

        cur_req = "R5";
        send(3'b011, 8'h55, 0); idle(1);
        send(3'b110, 8'h66, 1); idle(1);
        cur_req = "R12"; do_ack(); idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule